// File: doc/BRIEF.md
# Coherent Neighbourhood Reuse Controller

This controller sits in front of a nearest-neighbour search engine. It remembers the most recent neighbourhood results and lets a new query reuse one of them when the new query point lies close enough to an earlier one. Each of the eight slots holds a query position, a scalar reuse threshold and a valid flag. The slot index is the handle to the neighbour list, which is stored elsewhere. Slots are ranked by recency.

A query is tested against every slot in turn with a single comparator, one slot per cycle. After the last slot, the block either reports a hit carrying a slot index, or it sends a search request to the engine. When the engine finishes, the result goes into the least recently used slot. The block then reports that slot together with the number of neighbours worth copying.

In k-nearest mode the engine is asked for one extra neighbour. The threshold is derived from the distances of the two farthest neighbours, using two host-supplied fixed-point coefficients that encode the approximation tolerance. In radius mode the engine is asked for an enlarged ball, and the new query's own radius is subtracted from the stored threshold.

Top module: `cnc_ctrl`

## Requirements
- R1: After reset every slot is invalid and never hits: q_ready is 1, hit_valid, srch_valid and wr_valid are 0, and the first query misses.
- R2: A query is accepted on a clock edge where q_valid and q_ready are both 1. q_ready is 0 until the response. Exactly one of hit_valid or srch_valid pulses for one cycle, and it does so exactly ENT+1 (9) cycles after the accepting edge.
- R3: On a k-nearest miss, srch_inf is 1, srch_rad is all ones (1023), and srch_pos equals the query position. q_pos holds signed 8-bit coordinates, with dimension 0 in bits [7:0] and dimension 1 in bits [15:8].
- R4: On a radius-mode miss, srch_inf is 0 and srch_rad = min(floor(alpha·q_rad/256), 1023), where alpha is unsigned with 8 fraction bits.
- R5: When a k-nearest search completes, the slot threshold becomes floor((coef_far·done_dk1 − coef_near·done_dk)/256). The value is clamped to 0 when the difference is not positive and to 1023 at the top. done_dk1 is the (k+1)-th distance and done_dk is the k-th distance.
- R6: In k-nearest mode, valid slot i hits when c_i > 0 and the squared Euclidean separation between the query and slot i is below c_i².
- R7: In radius mode, valid slot i hits when t = c_i − q_rad > 0 and the squared separation is below t². A slot filled in radius mode stores c_i equal to the issued radius from R4.
- R8: When several slots pass the test, hit_idx is the most recently used of them.
- R9: A hit makes the hit slot most recently used. A completed search overwrites the least recently used slot and makes it most recently used. After reset, slots are replaced in the order 7, 6, …, 0.
- R10: One cycle after done_valid while a search is outstanding, wr_valid pulses with wr_idx set to the replaced slot. In k-nearest mode wr_len = done_cnt − 1, or 0 when done_cnt is 0, because the farthest element is dropped. In radius mode wr_len = done_cnt, the count of non-empty elements.
- R11: done_valid while no search is outstanding is ignored: no wr_valid and no slot change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_knn | input | 1 | 1 = k-nearest mode, 0 = radius mode |
| coef_far | input | KW | Weight of the (k+1)-th distance, 8 fraction bits |
| coef_near | input | KW | Weight of the k-th distance, 8 fraction bits |
| alpha | input | AW | Radius enlargement factor, 8 fraction bits |
| q_valid | input | 1 | Query present |
| q_ready | output | 1 | Controller idle, query can be taken |
| q_pos | input | DIM*CW | Query position, signed coordinates |
| q_rad | input | DW | Query radius (radius mode) |
| hit_valid | output | 1 | Reuse found |
| hit_idx | output | IW | Slot that is reused |
| srch_valid | output | 1 | Search request pulse |
| srch_inf | output | 1 | Search radius is unbounded |
| srch_pos | output | DIM*CW | Search position |
| srch_rad | output | DW | Search radius |
| done_valid | input | 1 | Search engine result available |
| done_dk | input | DW | k-th neighbour distance |
| done_dk1 | input | DW | (k+1)-th neighbour distance |
| done_cnt | input | LW | Number of non-empty elements returned |
| wr_valid | output | 1 | Slot refill pulse |
| wr_idx | output | IW | Slot being refilled |
| wr_len | output | LW | Neighbours to copy into the slot |

## Verification
The bench sweeps query points on a grid across the signed coordinate range in both modes, with both a zero and a non-zero tolerance. Slots that overlap therefore produce multiple hits. A design that picked the lowest index instead of the most recent one would report a wrong hit_idx, and a design that stopped scanning at the first hit would respond early. Squared separations that fall exactly on c² must miss, so a `<=` comparison shows up as a false hit. Inverted (k+1)-th and k-th distances must clamp the threshold to zero; without the clamp, the wrapped value gives huge thresholds and spurious hits. Radius overflow must saturate at 1023. A done pulse arriving while idle must leave every slot untouched. Botched recency updates show up as the wrong slot being refilled.

// File: rtl/cnc_ctrl.sv
module cnc_ctrl #(
  parameter int ENT = 8,
  parameter int DIM = 2,
  parameter int CW  = 8,
  parameter int DW  = 10,
  parameter int FB  = 8,
  parameter int KW  = 9,
  parameter int AW  = 10,
  parameter int LW  = 4,
  localparam int IW = $clog2(ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_knn,
  input  logic [KW-1:0]     coef_far,
  input  logic [KW-1:0]     coef_near,
  input  logic [AW-1:0]     alpha,
  input  logic              q_valid,
  output logic              q_ready,
  input  logic [DIM*CW-1:0] q_pos,
  input  logic [DW-1:0]     q_rad,
  output logic              hit_valid,
  output logic [IW-1:0]     hit_idx,
  output logic              srch_valid,
  output logic              srch_inf,
  output logic [DIM*CW-1:0] srch_pos,
  output logic [DW-1:0]     srch_rad,
  input  logic              done_valid,
  input  logic [DW-1:0]     done_dk,
  input  logic [DW-1:0]     done_dk1,
  input  logic [LW-1:0]     done_cnt,
  output logic              wr_valid,
  output logic [IW-1:0]     wr_idx,
  output logic [LW-1:0]     wr_len
);
  localparam int XW = 2*CW + 2;
  localparam int MW = 2*(CW + DW) + 4;
  localparam int PW = DW + KW;
  localparam int RW = DW + AW;
  localparam logic [DW-1:0] DMAX = {DW{1'b1}};
  localparam logic [IW-1:0] LAST = IW'(ENT-1);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_WAIT} st_t;
  st_t st;

  logic              ev [ENT];
  logic [DIM*CW-1:0] ep [ENT];
  logic [DW-1:0]     ec [ENT];
  logic [IW-1:0]     age[ENT];

  logic [DIM*CW-1:0] qp;
  logic [DW-1:0]     qr;
  logic [IW-1:0]     idx, best_idx, best_age, lru;
  logic              found;

  // squared separation between latched query and scanned slot
  logic [MW-1:0] sep;
  always_comb begin
    logic signed [XW-1:0] a, b, dx, sq;
    sep = '0;
    for (int d = 0; d < DIM; d++) begin
      a   = XW'($signed(qp[d*CW +: CW]));
      b   = XW'($signed(ep[idx][d*CW +: CW]));
      dx  = a - b;
      sq  = dx * dx;
      sep = sep + MW'($unsigned(sq));
    end
  end

  logic signed [DW+1:0] thr;
  logic [MW-1:0] thr_sq;
  logic thr_pos, hit_now, take, fin_found;
  logic [IW-1:0] fin_idx;

  assign thr       = $signed({2'b00, ec[idx]}) - $signed({2'b00, (mode_knn ? {DW{1'b0}} : qr)});
  assign thr_pos   = !thr[DW+1] && (thr != '0);
  assign thr_sq    = MW'(thr[DW-1:0]) * MW'(thr[DW-1:0]);
  assign hit_now   = ev[idx] && thr_pos && (sep < thr_sq);
  assign take      = hit_now && (!found || (age[idx] < best_age));
  assign fin_found = found || hit_now;
  assign fin_idx   = take ? idx : best_idx;

  // k-nearest threshold from the two farthest distances
  logic [PW-1:0] pa, pb, pshift;
  logic signed [PW:0] pd;
  logic [DW-1:0] c_knn;
  assign pa     = PW'(done_dk1) * PW'(coef_far);
  assign pb     = PW'(done_dk)  * PW'(coef_near);
  assign pd     = $signed({1'b0, pa}) - $signed({1'b0, pb});
  assign pshift = pd[PW-1:0] >> FB;
  assign c_knn  = (pd[PW] || pd == '0) ? '0 :
                  (pshift > PW'(DMAX)) ? DMAX : pshift[DW-1:0];

  // enlarged radius for radius-mode misses
  logic [RW-1:0] pr, prs;
  logic [DW-1:0] rad_x;
  assign pr    = RW'(qr) * RW'(alpha);
  assign prs   = pr >> FB;
  assign rad_x = (prs > RW'(DMAX)) ? DMAX : prs[DW-1:0];

  always_comb begin
    lru = '0;
    for (int i = 0; i < ENT; i++)
      if (age[i] == LAST) lru = IW'(i);
  end

  logic          prom_en;
  logic [IW-1:0] prom_slot;
  assign prom_en   = (st == S_SCAN && idx == LAST && fin_found) || (st == S_WAIT && done_valid);
  assign prom_slot = (st == S_WAIT) ? lru : fin_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) age[i] <= IW'(i);
    end else if (prom_en) begin
      for (int i = 0; i < ENT; i++) begin
        if (IW'(i) == prom_slot)        age[i] <= '0;
        else if (age[i] < age[prom_slot]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      qp <= '0; qr <= '0;
      idx <= '0; found <= 1'b0; best_idx <= '0; best_age <= '0;
      hit_valid <= 1'b0; hit_idx <= '0;
      srch_valid <= 1'b0; srch_inf <= 1'b0; srch_rad <= '0;
      wr_valid <= 1'b0; wr_idx <= '0; wr_len <= '0;
      for (int i = 0; i < ENT; i++) begin
        ev[i] <= 1'b0; ep[i] <= '0; ec[i] <= '0;
      end
    end else begin
      hit_valid  <= 1'b0;
      srch_valid <= 1'b0;
      wr_valid   <= 1'b0;
      case (st)
        S_IDLE: if (q_valid) begin
          qp <= q_pos; qr <= q_rad;
          idx <= '0; found <= 1'b0;
          st <= S_SCAN;
        end
        S_SCAN: begin
          if (take) begin
            found <= 1'b1; best_idx <= idx; best_age <= age[idx];
          end
          if (idx == LAST) begin
            if (fin_found) begin
              hit_valid <= 1'b1; hit_idx <= fin_idx;
              st <= S_IDLE;
            end else begin
              srch_valid <= 1'b1;
              srch_inf   <= mode_knn;
              srch_rad   <= mode_knn ? DMAX : rad_x;
              st <= S_WAIT;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_WAIT: if (done_valid) begin
          ev[lru] <= 1'b1;
          ep[lru] <= qp;
          ec[lru] <= mode_knn ? c_knn : srch_rad;
          wr_valid <= 1'b1;
          wr_idx   <= lru;
          wr_len   <= !mode_knn ? done_cnt : (done_cnt == '0 ? '0 : done_cnt - 1'b1);
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign q_ready  = (st == S_IDLE);
  assign srch_pos = qp;
endmodule

// File: rtl/cnc_ctrl_chk.sv
module cnc_ctrl_chk #(
  parameter int ENT = 8
) (
  input logic clk,
  input logic rst_n,
  input logic mode_knn,
  input logic q_valid,
  input logic q_ready,
  input logic hit_valid,
  input logic srch_valid,
  input logic srch_inf,
  input logic done_valid,
  input logic wr_valid
);
  logic [5:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (q_valid && q_ready)     cnt <= 6'd1;
    else if (hit_valid || srch_valid) cnt <= '0;
    else if (cnt != '0 && cnt != '1) cnt <= cnt + 6'd1;
  end

  // R2
  resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid || srch_valid) |-> cnt == 6'(ENT + 1));
  // R2
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_valid && srch_valid));
  // R3
  knn_unbounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_valid && mode_knn) |-> srch_inf);
  // R4
  rad_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_valid && !mode_knn) |-> !srch_inf);
  // R10
  wr_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(done_valid));
  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_ready) |=> !q_ready);
endmodule

bind cnc_ctrl cnc_ctrl_chk #(.ENT(ENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_knn(mode_knn),
  .q_valid(q_valid), .q_ready(q_ready),
  .hit_valid(hit_valid), .srch_valid(srch_valid), .srch_inf(srch_inf),
  .done_valid(done_valid), .wr_valid(wr_valid)
);

// File: tb/cnc_ctrl_tb.sv
module cnc_ctrl_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, mode_knn, q_valid, q_ready, hit_valid, srch_valid, srch_inf;
  logic done_valid, wr_valid;
  logic [8:0]  coef_far, coef_near;
  logic [9:0]  alpha, q_rad, srch_rad, done_dk, done_dk1;
  logic [15:0] q_pos, srch_pos;
  logic [2:0]  hit_idx, wr_idx;
  logic [3:0]  done_cnt, wr_len;

  cnc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_knn(mode_knn),
    .coef_far(coef_far), .coef_near(coef_near), .alpha(alpha),
    .q_valid(q_valid), .q_ready(q_ready), .q_pos(q_pos), .q_rad(q_rad),
    .hit_valid(hit_valid), .hit_idx(hit_idx),
    .srch_valid(srch_valid), .srch_inf(srch_inf), .srch_pos(srch_pos), .srch_rad(srch_rad),
    .done_valid(done_valid), .done_dk(done_dk), .done_dk1(done_dk1), .done_cnt(done_cnt),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_len(wr_len)
  );

  int checks = 0, errors = 0;
  int mv[8], mx[8], my[8], mc[8], mage[8];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat(int v);
    return (v > 1023) ? 1023 : v;
  endfunction

  task automatic promote(int p);
    int pa = mage[p];
    for (int i = 0; i < 8; i++)
      if (i == p) mage[i] = 0;
      else if (mage[i] < pa) mage[i]++;
  endtask

  task automatic query(int x, int y, int r, int dk, int dk1, int cnt);
    int best = -1, nh = 0, anyv = 0, n, lru = 0, cexp, lexp;
    for (int i = 0; i < 8; i++) begin
      int thr, sep;
      if (mv[i] == 0) continue;
      anyv = 1;
      thr = mode_knn ? mc[i] : mc[i] - r;
      sep = (x - mx[i]) * (x - mx[i]) + (y - my[i]) * (y - my[i]);
      if (thr > 0 && sep < thr * thr) begin
        nh++;
        if (best < 0 || mage[i] < mage[best]) best = i;
      end
    end
    @(negedge clk);
    chk("R2 ready before query", int'(q_ready), 1);
    q_valid = 1'b1;
    q_pos   = {y[7:0], x[7:0]};
    q_rad   = r[9:0];
    @(posedge clk);
    @(negedge clk);
    q_valid = 1'b0;
    n = 1;
    chk("R2 busy", int'(q_ready), 0);
    while (!(hit_valid || srch_valid) && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk("R2 latency", n, 9);
    if (best >= 0) begin
      chk(nh > 1 ? "R8 hit" : (mode_knn ? "R6 hit" : "R7 hit"), int'(hit_valid), 1);
      chk(nh > 1 ? "R8 index" : (mode_knn ? "R6 index" : "R7 index"), int'(hit_idx), best);
      promote(best);
    end else begin
      chk(anyv == 0 ? "R1 first miss" : (mode_knn ? "R6 miss" : "R7 miss"), int'(srch_valid), 1);
      chk(mode_knn ? "R3 inf" : "R4 inf", int'(srch_inf), int'(mode_knn));
      chk(mode_knn ? "R3 radius" : "R4 radius", int'(srch_rad),
          mode_knn ? 1023 : sat((int'(alpha) * r) >> 8));
      chk("R3 pos x", int'($signed(srch_pos[7:0])), x);
      chk("R3 pos y", int'($signed(srch_pos[15:8])), y);
      for (int i = 0; i < 8; i++) if (mage[i] == 7) lru = i;
      done_valid = 1'b1;
      done_dk    = dk[9:0];
      done_dk1   = dk1[9:0];
      done_cnt   = cnt[3:0];
      @(posedge clk);
      @(negedge clk);
      done_valid = 1'b0;
      lexp = mode_knn ? ((cnt == 0) ? 0 : cnt - 1) : cnt;
      chk("R10 wr_valid", int'(wr_valid), 1);
      chk("R9 replaced slot", int'(wr_idx), lru);
      chk("R10 wr_len", int'(wr_len), lexp);
      if (mode_knn) begin
        int t = int'(coef_far) * dk1 - int'(coef_near) * dk;
        cexp = (t <= 0) ? 0 : sat(t >> 8);   // R5
      end else begin
        cexp = sat((int'(alpha) * r) >> 8);
      end
      mv[lru] = 1; mx[lru] = x; my[lru] = y; mc[lru] = cexp;
      promote(lru);
    end
  endtask

  task automatic sweep(int seed, int rbase);
    for (int x = -128; x < 128; x += 5)
      for (int y = -8; y <= 8; y += 4) begin
        int dk  = ((x * 7 + y * 3 + seed) & 63);
        int dk1 = dk + ((x + y * 5 + seed) & 31) - 6;
        if (dk1 < 0) dk1 = 0;
        query(x, y, ((x * 3 + y + seed) & 31) + rbase, dk, dk1, (x + y + seed) & 15);
      end
  endtask

  initial begin
    rst_n = 1'b0; mode_knn = 1'b1; q_valid = 1'b0; q_pos = '0; q_rad = '0;
    coef_far = 9'd128; coef_near = 9'd128; alpha = 10'd384;
    done_valid = 1'b0; done_dk = '0; done_dk1 = '0; done_cnt = '0;
    for (int i = 0; i < 8; i++) begin mv[i] = 0; mx[i] = 0; my[i] = 0; mc[i] = 0; mage[i] = i; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready", int'(q_ready), 1);
    chk("R1 hit_valid", int'(hit_valid), 0);
    chk("R1 srch_valid", int'(srch_valid), 0);
    chk("R1 wr_valid", int'(wr_valid), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++)
      query(-120 + 30 * i, 0, 0, 10 + 2 * i, 30 + 5 * i, i + 1);
    query(-120, 0, 0, 0, 0, 0);
    sweep(0, 0);

    coef_far = 9'd142; coef_near = 9'd114;
    sweep(11, 0);
    query(0, 0, 0, 50, 20, 0);     // R5 clamp: inverted distances

    @(negedge clk);
    done_valid = 1'b1; done_cnt = 4'd5;
    @(posedge clk);
    @(negedge clk);
    chk("R11 stray done", int'(wr_valid), 0);
    done_valid = 1'b0;
    query(0, 0, 0, 5, 9, 3);       // R11 slots unchanged per model

    mode_knn = 1'b0;
    sweep(23, 2);
    query(100, 100, 800, 0, 0, 7); // R4 saturation
    query(100, 100, 900, 0, 0, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule